// File: doc/BRIEF.md
# Cell Balancer Output Supervisor

This block decides whether the drive enables of a multichannel cell-balancing controller may be on. It keeps the most recent balance command in a register. It passes the command's channel bits to the outputs only while three things are true at once: a command is executing, the communication watchdog has not timed out, and the die is not in thermal shutdown. A serial-link decoder upstream supplies three things. The first is a strobe for each received command byte, with a flag that says whether the byte's address matched. The second is an execute strobe that carries a channel word. The third is a digitized die-temperature code. A supply-good input acts as a power-on reset for the command state.

Watchdog timeout and overtemperature both remove the drive without erasing the stored command. When the die cools, balancing resumes with that stored word. Any byte with a matching address restarts the timeout count, even if the transaction it starts is never completed. After a timeout, only a fresh execute strobe brings the outputs back. Temperature codes are unsigned degrees Celsius. The timeout is a parameterized number of clock cycles.

Top module: `cell_bal_guard`

## Requirements
- R1: On a clock edge where `exec_vld_i` is high and `supply_ok_i` is high, `cmd_o` takes `exec_cmd_i` and execution starts. `ch_en_o` shows the new command one edge later, unless a disabling condition holds.
- R2: A command byte with `byte_vld_i` and `addr_ok_i` both high clears the watchdog count. An execute strobe also clears it. A cleared count does not run out until `WDT_CYCLES` further edges have passed.
- R3: A byte with `byte_vld_i` high and `addr_ok_i` low leaves the watchdog count unchanged.
- R4: While a command executes, `wdt_exp_o` rises on the `WDT_CYCLES`-th edge after the last clear if no clear occurs in between. `ch_en_o` is all zero from the next edge.
- R5: After expiry, `cmd_o` keeps the stored command. Matched bytes do not lower `wdt_exp_o`. Only an execute strobe lowers it and restores the enables.
- R6: The watchdog does not count while no command is executing.
- R7: `therm_sd_o` rises on the edge where `temp_code_i >= TEMP_HOT`. `ch_en_o` is all zero from the next edge.
- R8: `therm_sd_o` falls only on an edge where `temp_code_i <= TEMP_COOL`. Between the two thresholds it keeps its state. After it falls, the stored command drives `ch_en_o` again.
- R9: During thermal shutdown, execute strobes still store their command and `therm_sd_o` reports the shutdown.
- R10: While `supply_ok_i` is low, each edge clears `cmd_o`, execution and `wdt_exp_o`. An execute strobe on such an edge is discarded.
- R11: While `rst_ni` is low, `ch_en_o`, `cmd_o`, `wdt_exp_o` and `therm_sd_o` are all zero.
- R12: A matched byte on the very edge where the count would expire wins. `wdt_exp_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | One-cycle strobe per received command byte |
| addr_ok_i | input | 1 | Address of the current byte matched |
| exec_vld_i | input | 1 | One-cycle execute strobe |
| exec_cmd_i | input | N_CH | Channel word carried by the execute strobe |
| temp_code_i | input | TEMP_W | Die temperature, unsigned degrees C |
| supply_ok_i | input | 1 | Supply good; low acts as power-on reset |
| ch_en_o | output | N_CH | Registered per-channel drive enables |
| cmd_o | output | N_CH | Stored command readback |
| wdt_exp_o | output | 1 | Watchdog timed out |
| therm_sd_o | output | 1 | Thermal shutdown status |

## Verification
Two functions can meet on one edge: the watchdog reaching its limit, and a matched byte clearing the count. The bench starts a command and waits exactly `WDT_CYCLES - 1` idle edges. It then presents a matched byte on the edge that would otherwise expire the timer. It judges that `wdt_exp_o` stays low and that a full new window is needed before expiry. A second meeting point is covered by strobing execute in a cycle where `supply_ok_i` is low, and confirming that the command is discarded.

// File: rtl/bal_guard_pkg.sv
package bal_guard_pkg;
  typedef enum logic {
    TH_RUN = 1'b0,
    TH_HOT = 1'b1
  } th_state_e;
endpackage

// File: rtl/bal_cmd_reg.sv
module bal_cmd_reg #(
  parameter int N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            supply_ok_i,
  input  logic            exec_vld_i,
  input  logic [N_CH-1:0] exec_cmd_i,
  output logic [N_CH-1:0] cmd_o,
  output logic            run_o
);
  logic [N_CH-1:0] cmd_q;
  logic            run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      run_q <= 1'b0;
    end else if (!supply_ok_i) begin
      cmd_q <= '0;
      run_q <= 1'b0;
    end else if (exec_vld_i) begin
      cmd_q <= exec_cmd_i;
      run_q <= 1'b1;
    end
  end

  assign cmd_o = cmd_q;
  assign run_o = run_q;
endmodule

// File: rtl/bal_wdt.sv
module bal_wdt #(
  parameter int WDT_CYCLES = 150_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic kick_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int CNT_W = $clog2(WDT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WDT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clr_i || start_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;  // expired flag is sticky until a new execute
    end else if (run_i && !exp_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/bal_therm.sv
module bal_therm
  import bal_guard_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TEMP_HOT  = 155,
  parameter int TEMP_COOL = 145
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              sd_o
);
  localparam logic [TEMP_W-1:0] HOT_C  = TEMP_W'(TEMP_HOT);
  localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(TEMP_COOL);

  th_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TH_RUN:  if (temp_i >= HOT_C)  st_d = TH_HOT;
      TH_HOT:  if (temp_i <= COOL_C) st_d = TH_RUN;
      default: st_d = TH_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TH_RUN;
    else         st_q <= st_d;
  end

  assign sd_o = (st_q == TH_HOT);
endmodule

// File: rtl/cell_bal_guard.sv
module cell_bal_guard #(
  parameter int N_CH       = 6,
  parameter int TEMP_W     = 8,
  parameter int WDT_CYCLES = 150_000_000,
  parameter int TEMP_HOT   = 155,
  parameter int TEMP_COOL  = 145
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              addr_ok_i,
  input  logic              exec_vld_i,
  input  logic [N_CH-1:0]   exec_cmd_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              supply_ok_i,
  output logic [N_CH-1:0]   ch_en_o,
  output logic [N_CH-1:0]   cmd_o,
  output logic              wdt_exp_o,
  output logic              therm_sd_o
);
  logic [N_CH-1:0] cmd_w;
  logic            run_w;
  logic            exp_w;
  logic            sd_w;
  logic            allow_w;
  logic            kick_w;

  bal_cmd_reg #(.N_CH(N_CH)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .exec_vld_i (exec_vld_i),
    .exec_cmd_i (exec_cmd_i),
    .cmd_o      (cmd_w),
    .run_o      (run_w)
  );

  assign kick_w = byte_vld_i && addr_ok_i;

  bal_wdt #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!supply_ok_i),
    .start_i(exec_vld_i),
    .kick_i (kick_w),
    .run_i  (run_w),
    .exp_o  (exp_w)
  );

  bal_therm #(
    .TEMP_W   (TEMP_W),
    .TEMP_HOT (TEMP_HOT),
    .TEMP_COOL(TEMP_COOL)
  ) u_therm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(temp_code_i),
    .sd_o  (sd_w)
  );

  assign allow_w = run_w && !exp_w && !sd_w;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= cmd_w[g] && allow_w;
    end
    assign ch_en_o[g] = en_q;
  end

  assign cmd_o      = cmd_w;
  assign wdt_exp_o  = exp_w;
  assign therm_sd_o = sd_w;
endmodule

// File: rtl/bal_guard_chk.sv
module bal_guard_chk #(
  parameter int N_CH      = 6,
  parameter int TEMP_W    = 8,
  parameter int TEMP_HOT  = 155,
  parameter int TEMP_COOL = 145
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic              addr_ok_i,
  input logic              exec_vld_i,
  input logic [N_CH-1:0]   exec_cmd_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic              supply_ok_i,
  input logic [N_CH-1:0]   ch_en_o,
  input logic [N_CH-1:0]   cmd_o,
  input logic              wdt_exp_o,
  input logic              therm_sd_o
);
  // R1
  exec_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_vld_i && supply_ok_i) |=> (cmd_o == $past(exec_cmd_i)) && !wdt_exp_o);

  // R1
  en_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ch_en_o & ~$past(cmd_o)) == '0));

  // R2
  kick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && addr_ok_i && !wdt_exp_o) |=> !wdt_exp_o);

  // R4
  exp_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_exp_o |=> (ch_en_o == '0));

  // R7
  sd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_sd_o |=> (ch_en_o == '0));

  // R8
  sd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_sd_o && temp_code_i > TEMP_W'(TEMP_COOL)) |=> therm_sd_o);

  // R7
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!therm_sd_o && temp_code_i < TEMP_W'(TEMP_HOT)) |=> !therm_sd_o);

  // R10
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (cmd_o == '0) && !wdt_exp_o);
endmodule

bind cell_bal_guard bal_guard_chk #(
  .N_CH     (N_CH),
  .TEMP_W   (TEMP_W),
  .TEMP_HOT (TEMP_HOT),
  .TEMP_COOL(TEMP_COOL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld_i),
  .addr_ok_i  (addr_ok_i),
  .exec_vld_i (exec_vld_i),
  .exec_cmd_i (exec_cmd_i),
  .temp_code_i(temp_code_i),
  .supply_ok_i(supply_ok_i),
  .ch_en_o    (ch_en_o),
  .cmd_o      (cmd_o),
  .wdt_exp_o  (wdt_exp_o),
  .therm_sd_o (therm_sd_o)
);

// File: tb/cell_bal_guard_test.sv
`timescale 1ns/1ps
module cell_bal_guard_test;
  localparam int N_CH = 6;
  localparam int TW   = 8;
  localparam int LIM  = 16;
  localparam int NV   = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bv = 1'b0, ao = 1'b0, ex = 1'b0, sup = 1'b1;
  logic [N_CH-1:0] cmd_in = '0;
  logic [TW-1:0] temp = 8'd25;
  logic [N_CH-1:0] en, cmd_rb;
  logic          wexp, sd;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cell_bal_guard #(
    .N_CH(N_CH), .TEMP_W(TW), .WDT_CYCLES(LIM), .TEMP_HOT(155), .TEMP_COOL(145)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(bv), .addr_ok_i(ao),
    .exec_vld_i(ex), .exec_cmd_i(cmd_in), .temp_code_i(temp),
    .supply_ok_i(sup), .ch_en_o(en), .cmd_o(cmd_rb),
    .wdt_exp_o(wexp), .therm_sd_o(sd)
  );

  // {bv, ao, ex, cmd[6], temp[8], sup, exp_en[6], exp_wdt, exp_sd, exp_cmd[6]}
  localparam logic [31:0] VEC [NV] = '{
    {3'b111, 6'h2D, 8'd25,  1'b1, 6'h2D, 2'b00, 6'h2D}, // R1
    {3'b110, 6'h00, 8'd25,  1'b1, 6'h2D, 2'b00, 6'h2D}, // R2
    {3'b110, 6'h00, 8'd160, 1'b1, 6'h00, 2'b01, 6'h2D}, // R7
    {3'b110, 6'h00, 8'd150, 1'b1, 6'h00, 2'b01, 6'h2D}, // R8
    {3'b110, 6'h00, 8'd146, 1'b1, 6'h00, 2'b01, 6'h2D}, // R8
    {3'b110, 6'h00, 8'd145, 1'b1, 6'h2D, 2'b00, 6'h2D}, // R8
    {3'b111, 6'h12, 8'd150, 1'b1, 6'h12, 2'b00, 6'h12}, // R7
    {3'b110, 6'h00, 8'd155, 1'b1, 6'h00, 2'b01, 6'h12}, // R7
    {3'b111, 6'h3F, 8'd155, 1'b1, 6'h00, 2'b01, 6'h3F}, // R9
    {3'b110, 6'h00, 8'd100, 1'b1, 6'h3F, 2'b00, 6'h3F}, // R8
    {3'b100, 6'h00, 8'd100, 1'b1, 6'h3F, 2'b00, 6'h3F}, // R3
    {3'b110, 6'h00, 8'd100, 1'b0, 6'h00, 2'b00, 6'h00}, // R10
    {3'b110, 6'h00, 8'd100, 1'b1, 6'h00, 2'b00, 6'h00}, // R10
    {3'b111, 6'h01, 8'd100, 1'b1, 6'h01, 2'b00, 6'h01}  // R1
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [N_CH-1:0] e_en,
                         input logic e_exp, input logic e_sd,
                         input logic [N_CH-1:0] e_cmd);
    chk(en == e_en,       req, "ch_en", 32'(en), 32'(e_en));
    chk(wexp == e_exp,    req, "wdt_exp", 32'(wexp), 32'(e_exp));
    chk(sd == e_sd,       req, "therm_sd", 32'(sd), 32'(e_sd));
    chk(cmd_rb == e_cmd,  req, "cmd", 32'(cmd_rb), 32'(e_cmd));
  endtask

  task automatic do_exec(input logic [N_CH-1:0] c);
    ex = 1'b1; bv = 1'b1; ao = 1'b1; cmd_in = c;
    step();
    ex = 1'b0; bv = 1'b0; ao = 1'b0; cmd_in = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk_all("R11", '0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      bv = v[31]; ao = v[30]; ex = v[29]; cmd_in = v[28:23];
      temp = v[22:15]; sup = v[14];
      step();
      bv = 1'b0; ao = 1'b0; ex = 1'b0; cmd_in = '0;
      step();
      step();
      chk_all($sformatf("vec%0d", i), v[13:8], v[7], v[6], v[5:0]);
    end

    // R4/R5 exact expiry, command retained
    temp = 8'd30;
    do_exec(6'h15);
    repeat (LIM - 1) step();
    chk(wexp == 1'b0, "R4", "before limit", 32'(wexp), 0);
    chk(en == 6'h15, "R4", "en before limit", 32'(en), 32'h15);
    step();
    chk(wexp == 1'b1, "R4", "at limit", 32'(wexp), 1);
    step();
    chk(en == '0, "R4", "en after expiry", 32'(en), 0);
    chk(cmd_rb == 6'h15, "R5", "cmd kept", 32'(cmd_rb), 32'h15);

    // R5 matched byte does not revive
    bv = 1'b1; ao = 1'b1;
    step();
    bv = 1'b0; ao = 1'b0;
    repeat (LIM + 2) step();
    chk(wexp == 1'b1, "R5", "byte leaves expired", 32'(wexp), 1);
    chk(en == '0, "R5", "en stays off", 32'(en), 0);
    do_exec(6'h15);
    chk(wexp == 1'b0, "R5", "exec clears", 32'(wexp), 0);
    step();
    chk(en == 6'h15, "R5", "en restored", 32'(en), 32'h15);

    // R12 kick on expiry edge wins; R2 fresh window
    do_exec(6'h0A);
    repeat (LIM - 1) step();
    bv = 1'b1; ao = 1'b1;
    step();
    bv = 1'b0; ao = 1'b0;
    chk(wexp == 1'b0, "R12", "kick at boundary", 32'(wexp), 0);
    repeat (LIM - 1) step();
    chk(wexp == 1'b0, "R2", "full new window", 32'(wexp), 0);
    step();
    chk(wexp == 1'b1, "R2", "expires after window", 32'(wexp), 1);

    // R3 mismatched bytes do not extend
    do_exec(6'h07);
    for (int k = 0; k < LIM - 1; k++) begin
      bv = 1'b1; ao = 1'b0;
      step();
    end
    bv = 1'b1; ao = 1'b0;
    step();
    bv = 1'b0;
    chk(wexp == 1'b1, "R3", "mismatch ignored", 32'(wexp), 1);

    // R10 supply drop clears expiry; exec during drop discarded
    sup = 1'b0;
    ex = 1'b1; cmd_in = 6'h3C;
    step();
    ex = 1'b0; cmd_in = '0;
    step();
    chk_all("R10", '0, 1'b0, 1'b0, '0);
    sup = 1'b1;

    // R6 idle timer does not run
    repeat (2 * LIM) step();
    chk(wexp == 1'b0, "R6", "no count idle", 32'(wexp), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule